// File: doc/BRIEF.md
# Time-Slot Input Demultiplexer with Word Reformatting

This block sits behind one input link that carries a time-division-multiplexed stream of 32-bit words from many front-end time-to-digital converters (TDCs). Each word comes with a small side-band of control bits. Every incoming word is sorted into one of five classes using programmable match registers: cycle separator, empty-slot filler, TDC header, TDC trailer or plain data. A separator restarts the slot count. Every other word belongs to the next slot in turn, so the identity of the source converter comes from the word's position in the cycle and not from its contents.

Headers, trailers and data words that land in an enabled slot are written into that slot's buffer partition. The partition index, address and data are driven on a write port. On the way in, a header's identifier field is rewritten with the slot number. A word that carries a link parity fault or a converter parity flag has its type nibble replaced by a programmable error code. Each partition is a circular buffer with its own write pointer, which is exported. The readout side returns its read pointers, and the block stops writing to a partition once it is full. Single-cycle pulses report trailer arrival with the event number, parity faults, and a partition becoming full.

Top module: `tdm_demux_top`

## Requirements
- R1: Each valid word is compared against four match entries, 0 = separator, 1 = filler, 2 = header, 3 = trailer. An entry hits when the word equals its data pattern on every bit set in its data mask, and the control bits equal its control pattern on every bit set in its control mask. The lowest hitting index wins, and a word with no hit is data.
- R2: After reset no word is written until the first separator. A separator is never written itself, and the word that follows it belongs to slot 0.
- R3: Every non-separator word after synchronisation takes the current slot, and the slot then advances by one. Words arriving once all NUM_SLOTS slots of the cycle are used are dropped until the next separator.
- R4: A filler word uses up its slot but is never written and raises no pulse.
- R5: A clean header is written with bits 31:29 unchanged, bits 28:24 set to its 5-bit slot number and bits 23:0 unchanged.
- R6: Link parity is even over all 32 bits, with bit 27 acting as the parity bit. A written-class word with odd parity raises `link_perr` with its slot on `err_slot`, and is stored with bits 31:28 replaced by `err_code` and bits 27:0 unchanged. This replacement takes precedence over the header rewrite.
- R7: A written-class word with bit 26 set raises `tdc_perr` with its slot, and gets the same `err_code` replacement as in R6.
- R8: A word in a slot whose `slot_en` bit is 0 is not written and raises no pulse.
- R9: Each partition has a write pointer of log2(PART_DEPTH)+1 bits. The pointer is 0 after reset and is exported on `wr_ptr`. A write uses the pointer's low bits as `wr_addr` and then increments the pointer.
- R10: A partition is full when its write pointer minus `rd_ptr` equals PART_DEPTH. The write that makes it full raises `full_pulse` with `full_slot`. Later words for that partition are dropped until `rd_ptr` advances, although their parity pulses still occur.
- R11: A written trailer without a parity fault raises `trl_pulse` with `trl_slot` and `trl_evid` = word bits 23:12.
- R12: All outputs are registered. Every result appears in the cycle right after the clock edge that accepts the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ctrl | input | CTRL_W | Side-band control bits |
| cls_pat | input | 4x32 | Data pattern per match entry |
| cls_mask | input | 4x32 | Data compare mask per entry |
| cls_cpat | input | 4xCTRL_W | Control pattern per entry |
| cls_cmask | input | 4xCTRL_W | Control compare mask per entry |
| err_code | input | 4 | Replacement type nibble for faulty words |
| slot_en | input | NUM_SLOTS | Per-slot write enable |
| rd_ptr | input | NUM_SLOTSxPTR_W | Read pointer per partition |
| wr_en | output | 1 | Partition write strobe |
| wr_part | output | 5 | Partition index |
| wr_addr | output | ADDR_W | Address inside the partition |
| wr_data | output | 32 | Reformatted word |
| wr_ptr | output | NUM_SLOTSxPTR_W | Write pointer per partition |
| full_pulse | output | 1 | A partition just became full |
| full_slot | output | 5 | Partition that became full |
| trl_pulse | output | 1 | Clean trailer written |
| trl_slot | output | 5 | Slot of that trailer |
| trl_evid | output | EVID_W | Event number of that trailer |
| link_perr | output | 1 | Link parity fault |
| tdc_perr | output | 1 | Converter parity flag seen |
| err_slot | output | 5 | Slot of the parity fault |

## Verification
Every result comes from a single register stage, so a write, trailer pulse, parity pulse or full pulse is due exactly one cycle after the edge that takes the word. A word driven after the clock edge numbered k has its results due at cycle k+1. The bench's driver feeds each word through its own slot and pointer model and pushes every expected write or pulse into a per-output queue, stamped with that cycle number. A monitor samples on the falling edge and compares the stamp and the payload together, so an early or late event fails just as a wrong value does. Dropped words are checked by the absence of any unqueued event, and by the exported pointers at the end.

// File: rtl/tdm_demux_pkg.sv
// Shared constants and types of the time-slot demultiplexer.
// Assumes: slot numbers always fit the 5-bit header identifier field.
package tdm_demux_pkg;
    localparam int SLOT_W   = 5;
    localparam int WORD_W   = 32;
    localparam int NUM_CLS  = 4;   // matchable classes: sep, fill, hdr, trl

    // Match entry index equals enum value for the first four classes.
    typedef enum logic [2:0] {
        CLS_SEP  = 3'd0,
        CLS_FIL  = 3'd1,
        CLS_HDR  = 3'd2,
        CLS_TRL  = 3'd3,
        CLS_DATA = 3'd4
    } word_cls_e;
endpackage

// File: rtl/tdm_word_classifier.sv
// Sorts one word into a class by masked pattern compare on data and
// control bits. Lower entry index has priority; no hit means data.
// Assumes: purely combinational, inputs stable within the cycle.
module tdm_word_classifier
    import tdm_demux_pkg::*;
#(
    parameter int CTRL_W = 1
) (
    input  logic [WORD_W-1:0]               word,
    input  logic [CTRL_W-1:0]               ctrl,
    input  logic [NUM_CLS-1:0][WORD_W-1:0]  pat,
    input  logic [NUM_CLS-1:0][WORD_W-1:0]  mask,
    input  logic [NUM_CLS-1:0][CTRL_W-1:0]  cpat,
    input  logic [NUM_CLS-1:0][CTRL_W-1:0]  cmask,
    output word_cls_e                       cls
);
    logic [NUM_CLS-1:0] hit;

    // One masked comparator per match entry.
    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cmp
        assign hit[g] = (((word ^ pat[g]) & mask[g]) == '0) &&
                        (((ctrl ^ cpat[g]) & cmask[g]) == '0);
    end

    // Priority pick: separator over filler over header over trailer.
    always_comb begin
        if (hit[0])      cls = CLS_SEP;
        else if (hit[1]) cls = CLS_FIL;
        else if (hit[2]) cls = CLS_HDR;
        else if (hit[3]) cls = CLS_TRL;
        else             cls = CLS_DATA;
    end
endmodule

// File: rtl/tdm_slot_tracker.sv
// Tracks cycle synchronisation and the slot of the current word.
// A separator restarts at slot 0; other words advance by one and the
// count parks at NUM_SLOTS (out of range) until the next separator.
// Assumes: NUM_SLOTS <= 31.
module tdm_slot_tracker
    import tdm_demux_pkg::*;
#(
    parameter int NUM_SLOTS = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              is_sep,
    output logic              synced,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LIM = SLOT_W'(NUM_SLOTS);

    // Slot counter and sync flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced <= 1'b0;
            slot   <= '0;
        end else if (in_valid) begin
            if (is_sep) begin
                synced <= 1'b1;
                slot   <= '0;
            end else if (synced && slot < LIM) begin
                slot <= slot + 1'b1;
            end
        end
    end

    p_sep_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_sep) |=> (synced && slot == '0));

    p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_sep && synced && slot < LIM) |=> (slot == $past(slot) + 1'b1));
endmodule

// File: rtl/tdm_partition_ptrs.sv
// Per-partition circular write pointers with full and one-before-full
// detection against the read pointers returned by the readout side.
// Assumes: depth is 2**ADDR_W; readout never passes the write pointer.
module tdm_partition_ptrs
    import tdm_demux_pkg::*;
#(
    parameter int NUM_SLOTS = 18,
    parameter int ADDR_W    = 13,
    localparam int PTR_W    = ADDR_W + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [SLOT_W-1:0]                slot,
    input  logic [NUM_SLOTS-1:0][PTR_W-1:0]  rd_ptr,
    output logic [NUM_SLOTS-1:0][PTR_W-1:0]  wr_ptr,
    output logic [NUM_SLOTS-1:0]             full,
    output logic [NUM_SLOTS-1:0]             last
);
    localparam logic [PTR_W-1:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [PTR_W-1:0] LAST_V  = DEPTH_V - 1'b1;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_part
        logic [PTR_W-1:0] ptr_q;
        logic [PTR_W-1:0] occ;

        assign occ       = ptr_q - rd_ptr[s];
        assign full[s]   = (occ == DEPTH_V);
        assign last[s]   = (occ == LAST_V);
        assign wr_ptr[s] = ptr_q;

        // Advance this partition's pointer on each write to it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q <= '0;
            else if (we && slot == SLOT_W'(s))
                ptr_q <= ptr_q + 1'b1;
        end

        p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            occ <= DEPTH_V);

        p_hold_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
            full[s] |=> (ptr_q == $past(ptr_q)));
    end
endmodule

// File: rtl/tdm_demux_top.sv
// Time-slot input demultiplexer: classifies link words, assigns them to
// slots, rewrites headers and faulty words, and drives a registered
// partition write port plus trailer, parity and full pulses.
// Assumes: NUM_SLOTS <= 31, PART_DEPTH a power of two, one word per cycle.
module tdm_demux_top
    import tdm_demux_pkg::*;
#(
    parameter int NUM_SLOTS  = 18,
    parameter int PART_DEPTH = 8192,
    parameter int CTRL_W     = 1,
    parameter int EVID_LSB   = 12,
    parameter int EVID_W     = 12,
    localparam int ADDR_W    = $clog2(PART_DEPTH),
    localparam int PTR_W     = ADDR_W + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic [31:0]                      in_data,
    input  logic [CTRL_W-1:0]                in_ctrl,
    input  logic [3:0][31:0]                 cls_pat,
    input  logic [3:0][31:0]                 cls_mask,
    input  logic [3:0][CTRL_W-1:0]           cls_cpat,
    input  logic [3:0][CTRL_W-1:0]           cls_cmask,
    input  logic [3:0]                       err_code,
    input  logic [NUM_SLOTS-1:0]             slot_en,
    input  logic [NUM_SLOTS-1:0][PTR_W-1:0]  rd_ptr,
    output logic                             wr_en,
    output logic [4:0]                       wr_part,
    output logic [ADDR_W-1:0]                wr_addr,
    output logic [31:0]                      wr_data,
    output logic [NUM_SLOTS-1:0][PTR_W-1:0]  wr_ptr,
    output logic                             full_pulse,
    output logic [4:0]                       full_slot,
    output logic                             trl_pulse,
    output logic [4:0]                       trl_slot,
    output logic [EVID_W-1:0]                trl_evid,
    output logic                             link_perr,
    output logic                             tdc_perr,
    output logic [4:0]                       err_slot
);
    localparam logic [SLOT_W-1:0] LIM = SLOT_W'(NUM_SLOTS);
    localparam int TDC_FLAG_BIT = 26;

    word_cls_e           cls;
    logic                synced;
    logic [SLOT_W-1:0]   slot_cur;
    logic [NUM_SLOTS-1:0] full_vec, last_vec;
    logic                is_sep, is_fil, is_hdr, is_trl;
    logic                in_range, cand, do_write;
    logic                link_bad, tdc_bad, any_bad;
    logic [31:0]         new_data;

    tdm_word_classifier #(.CTRL_W(CTRL_W)) u_cls (
        .word(in_data), .ctrl(in_ctrl),
        .pat(cls_pat), .mask(cls_mask), .cpat(cls_cpat), .cmask(cls_cmask),
        .cls(cls)
    );

    tdm_slot_tracker #(.NUM_SLOTS(NUM_SLOTS)) u_trk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_sep(is_sep),
        .synced(synced), .slot(slot_cur)
    );

    tdm_partition_ptrs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .we(do_write), .slot(slot_cur),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .full(full_vec), .last(last_vec)
    );

    assign is_sep = (cls == CLS_SEP);
    assign is_fil = (cls == CLS_FIL);
    assign is_hdr = (cls == CLS_HDR);
    assign is_trl = (cls == CLS_TRL);

    // Decide whether the current word is a write candidate and if it fits.
    always_comb begin
        in_range = synced && (slot_cur < LIM);
        cand     = in_valid && in_range && !is_sep && !is_fil && slot_en[slot_cur];
        do_write = cand && !full_vec[slot_cur];
        link_bad = ^in_data;
        tdc_bad  = in_data[TDC_FLAG_BIT];
        any_bad  = link_bad || tdc_bad;
    end

    // Reformat: error code replacement first, else header slot rewrite.
    always_comb begin
        if (any_bad)
            new_data = {err_code, in_data[27:0]};
        else if (is_hdr)
            new_data = {in_data[31:29], slot_cur, in_data[23:0]};
        else
            new_data = in_data;
    end

    // Output register stage for write port and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_part    <= '0;
            wr_addr    <= '0;
            wr_data    <= '0;
            full_pulse <= 1'b0;
            full_slot  <= '0;
            trl_pulse  <= 1'b0;
            trl_slot   <= '0;
            trl_evid   <= '0;
            link_perr  <= 1'b0;
            tdc_perr   <= 1'b0;
            err_slot   <= '0;
        end else begin
            wr_en      <= do_write;
            if (do_write) begin
                wr_part <= slot_cur;
                wr_addr <= wr_ptr[slot_cur][ADDR_W-1:0];
                wr_data <= new_data;
            end
            full_pulse <= do_write && last_vec[slot_cur];
            full_slot  <= slot_cur;
            trl_pulse  <= do_write && is_trl && !any_bad;
            trl_slot   <= slot_cur;
            trl_evid   <= in_data[EVID_LSB +: EVID_W];
            link_perr  <= cand && link_bad;
            tdc_perr   <= cand && tdc_bad;
            err_slot   <= slot_cur;
        end
    end

    p_unsynced_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !synced) |=> !wr_en);

    p_filler_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_fil) |=> (!wr_en && !trl_pulse && !link_perr && !tdc_perr));

    p_disabled_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_range && !is_sep && !slot_en[slot_cur]) |=> (!wr_en && !link_perr));
endmodule

// File: tb/tdm_demux_top_tb.sv
`timescale 1ns/1ps
module tdm_demux_top_tb_top;
    localparam int NS = 18;
    localparam int DEPTH = 4;
    localparam int AW = 2;
    localparam int PW = AW + 1;
    localparam int EW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              in_valid;
    logic [31:0]       in_data;
    logic [0:0]        in_ctrl;
    logic [3:0][31:0]  cls_pat, cls_mask;
    logic [3:0][0:0]   cls_cpat, cls_cmask;
    logic [3:0]        err_code;
    logic [NS-1:0]     slot_en;
    logic [NS-1:0][PW-1:0] rd_ptr;
    logic              wr_en;
    logic [4:0]        wr_part;
    logic [AW-1:0]     wr_addr;
    logic [31:0]       wr_data;
    logic [NS-1:0][PW-1:0] wr_ptr;
    logic              full_pulse, trl_pulse, link_perr, tdc_perr;
    logic [4:0]        full_slot, trl_slot, err_slot;
    logic [EW-1:0]     trl_evid;

    tdm_demux_top #(.NUM_SLOTS(NS), .PART_DEPTH(DEPTH), .CTRL_W(1),
                    .EVID_LSB(12), .EVID_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ctrl(in_ctrl), .cls_pat(cls_pat), .cls_mask(cls_mask),
        .cls_cpat(cls_cpat), .cls_cmask(cls_cmask), .err_code(err_code),
        .slot_en(slot_en), .rd_ptr(rd_ptr), .wr_en(wr_en), .wr_part(wr_part),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ptr(wr_ptr),
        .full_pulse(full_pulse), .full_slot(full_slot), .trl_pulse(trl_pulse),
        .trl_slot(trl_slot), .trl_evid(trl_evid), .link_perr(link_perr),
        .tdc_perr(tdc_perr), .err_slot(err_slot)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail = 0;
    bit mon_on = 0;
    logic [95:0] wq[$], tq[$], lq[$], pq[$], fq[$];

    // Reference model state, built from the requirements.
    bit m_sync = 0;
    int m_slot = 0;
    int m_ptr[NS];
    int rd[NS];

    task automatic cmp(string tag, logic [95:0] act, logic [95:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic stray(string tag, logic [95:0] act);
        n_tests++;
        n_fail++;
        $display("FAIL %s unexpected event actual=%h expected=none", tag, act);
    endtask

    function automatic logic [31:0] mk(logic [31:0] w);
        logic [31:0] r = w;
        r[27] = 1'b0;
        r[27] = ^r;
        return r;
    endfunction

    function automatic int cls_of(logic [31:0] w, logic c);
        for (int i = 0; i < 4; i++)
            if ((((w ^ cls_pat[i]) & cls_mask[i]) == 0) &&
                (((c ^ cls_cpat[i][0]) & cls_cmask[i][0]) == 1'b0))
                return i;
        return 4;
    endfunction

    // Driver: apply one word and queue every result it must produce.
    task automatic send(logic [31:0] w, logic c);
        int k, s, occ;
        logic [31:0] d;
        bit lb, tbad, e;
        @(negedge clk);
        in_valid = 1'b1; in_data = w; in_ctrl = c;
        k = cls_of(w, c);
        if (k == 0) begin m_sync = 1; m_slot = 0; return; end
        if (!m_sync) return;
        s = m_slot;
        if (m_slot < NS) m_slot++;
        if (s >= NS || k == 1 || !slot_en[s]) return;
        lb = ^w; tbad = w[26]; e = lb | tbad;
        if (lb)   lq.push_back({32'(cyc + 1), 32'(s), 32'd0});
        if (tbad) pq.push_back({32'(cyc + 1), 32'(s), 32'd0});
        d = e ? {err_code, w[27:0]} : (k == 2 ? {w[31:29], 5'(s), w[23:0]} : w);
        occ = m_ptr[s] - rd[s];
        if (occ >= DEPTH) return;
        wq.push_back({32'(cyc + 1), 16'(s), 16'(m_ptr[s] % DEPTH), d});
        m_ptr[s]++;
        if (occ + 1 == DEPTH) fq.push_back({32'(cyc + 1), 32'(s), 32'd0});
        if (k == 3 && !e) tq.push_back({32'(cyc + 1), 32'(s), 32'(w[23:12])});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic set_rd(int s, int v);
        @(negedge clk);
        in_valid = 1'b0;
        rd[s] = v;
        rd_ptr[s] = PW'(v);
    endtask

    function automatic logic [31:0] dat(int tag);
        return mk(32'h4000_0000 | (32'(tag) & 32'h00FF_FFFF));
    endfunction

    // Monitor: pop and compare results one cycle after each word.
    always @(negedge clk) begin
        if (mon_on) begin
            if (wr_en) begin
                if (wq.size() != 0) cmp("R12 write", {32'(cyc), 16'(wr_part), 16'(wr_addr), wr_data}, wq.pop_front());
                else stray("R12 write", {32'(cyc), 16'(wr_part), 16'(wr_addr), wr_data});
            end
            if (trl_pulse) begin
                if (tq.size() != 0) cmp("R11 trailer", {32'(cyc), 32'(trl_slot), 32'(trl_evid)}, tq.pop_front());
                else stray("R11 trailer", {32'(cyc), 32'(trl_slot), 32'(trl_evid)});
            end
            if (link_perr) begin
                if (lq.size() != 0) cmp("R6 link parity", {32'(cyc), 32'(err_slot), 32'd0}, lq.pop_front());
                else stray("R6 link parity", {32'(cyc), 32'(err_slot), 32'd0});
            end
            if (tdc_perr) begin
                if (pq.size() != 0) cmp("R7 tdc parity", {32'(cyc), 32'(err_slot), 32'd0}, pq.pop_front());
                else stray("R7 tdc parity", {32'(cyc), 32'(err_slot), 32'd0});
            end
            if (full_pulse) begin
                if (fq.size() != 0) cmp("R10 full", {32'(cyc), 32'(full_slot), 32'd0}, fq.pop_front());
                else stray("R10 full", {32'(cyc), 32'(full_slot), 32'd0});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cls_pat[0] = 32'hF000_0000; cls_mask[0] = 32'hF000_0000; cls_cpat[0] = 1'b1; cls_cmask[0] = 1'b1;
        cls_pat[1] = 32'hE000_0000; cls_mask[1] = 32'hE000_0000; cls_cpat[1] = 1'b0; cls_cmask[1] = 1'b0;
        cls_pat[2] = 32'hA000_0000; cls_mask[2] = 32'hF000_0000; cls_cpat[2] = 1'b0; cls_cmask[2] = 1'b1;
        cls_pat[3] = 32'hB000_0000; cls_mask[3] = 32'hF000_0000; cls_cpat[3] = 1'b0; cls_cmask[3] = 1'b1;
        err_code = 4'h7;
        slot_en = '1;
        slot_en[6] = 1'b0;
        rd_ptr = '0;
        for (int s = 0; s < NS; s++) begin m_ptr[s] = 0; rd[s] = 0; end
        in_valid = 1'b0; in_data = '0; in_ctrl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 / R12: reset state of the outputs and pointers
        cmp("R9 reset outputs", {32'(wr_en), 32'(trl_pulse | link_perr | tdc_perr | full_pulse), 32'(wr_ptr[0])}, 96'd0);
        cmp("R9 reset pointers", {32'd0, 32'd0, 32'(wr_ptr != '0)}, 96'd0);
        mon_on = 1;

        // R2: words before the first separator are dropped
        send(dat(32'h11), 1'b0);
        send(mk(32'hA100_0022), 1'b0);

        // R2 R3 R4 R5 R6 R7 R8 R11: one cycle of mixed word types
        send(32'hF000_0000, 1'b1);
        send(mk(32'hA100_0123), 1'b0);        // slot 0 header rewrite (R5)
        send(dat(1), 1'b0);                   // slot 1 data
        send(mk(32'hE000_0000), 1'b0);        // slot 2 filler (R4)
        send(mk(32'hB00A_B055), 1'b0);        // slot 3 trailer evid 0x0AB (R11)
        send(dat(4) ^ 32'h0800_0000, 1'b0);   // slot 4 link parity fault (R6)
        send(mk(32'h4400_0005), 1'b0);        // slot 5 tdc flag (R7)
        send(dat(6), 1'b0);                   // slot 6 disabled (R8)
        send(mk(32'hA200_0007), 1'b0);        // slot 7 header
        send(mk(32'hB0FF_F008), 1'b0);        // slot 8 trailer evid 0xFFF

        // R1: control bit decides separator versus filler for an F word
        send(32'hF000_0000, 1'b1);
        send(mk(32'hF123_4567), 1'b0);        // slot 0 filler via entry 1
        send(dat(9), 1'b0);                   // slot 1
        send(mk(32'hA400_0000), 1'b0);        // slot 2 header with tdc flag: error wins (R5, R7)

        // R10: fill partition 0, then drop, then free space and wrap (R9)
        for (int i = 0; i < 5; i++) begin
            send(32'hF000_0000, 1'b1);
            send(dat(32'h100 + i), 1'b0);
        end
        set_rd(0, 2);
        send(32'hF000_0000, 1'b1);
        send(mk(32'hB012_3000), 1'b0);        // slot 0 trailer at wrapped address
        send(32'hF000_0000, 1'b1);
        send(dat(32'h200), 1'b0);             // makes slot 0 full again

        // R3: words past the last slot are dropped; trailer in slot 17
        send(32'hF000_0000, 1'b1);
        for (int i = 0; i < 20; i++)
            send((i == 17) ? mk(32'hB034_5000) : dat(32'h300 + i), 1'b0);
        idle(4);

        // R9: exported pointers match the model
        for (int s = 0; s < NS; s++)
            cmp("R9 wr_ptr", 96'(wr_ptr[s]), 96'(m_ptr[s] % (2 * DEPTH)));
        while (wq.size() != 0) begin n_tests++; n_fail++; $display("FAIL R12 missing write actual=none expected=%h", wq.pop_front()); end
        while (tq.size() != 0) begin n_tests++; n_fail++; $display("FAIL R11 missing trailer actual=none expected=%h", tq.pop_front()); end
        while (lq.size() != 0) begin n_tests++; n_fail++; $display("FAIL R6 missing pulse actual=none expected=%h", lq.pop_front()); end
        while (pq.size() != 0) begin n_tests++; n_fail++; $display("FAIL R7 missing pulse actual=none expected=%h", pq.pop_front()); end
        while (fq.size() != 0) begin n_tests++; n_fail++; $display("FAIL R10 missing pulse actual=none expected=%h", fq.pop_front()); end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule